// File: doc/BRIEF.md
# Eight-Slot Time Display Scanner

This block drives eight common-anode seven-segment digits that share one segment bus. At any moment exactly one digit is enabled, through an active-low one-hot select. The block steps through the eight positions in a fixed order. It shows a packed BCD time of day as hours, minutes and seconds, with a dash between each group. Each position stays lit for a programmable number of clock cycles. The default is 48000 cycles, which gives about 1 ms at 48 MHz. A full frame therefore refreshes quickly enough to look steady.

The time value and the blink phase are plain level inputs with no handshake. The scanner samples them on every clock, so there is no back-pressure. A counter upstream may update the time at any cycle. The next registered output then shows the new value for whichever position is active. When the blink phase input is high, the two dash positions are dark. This gives a separator that flashes at the seconds rate.

Top module: `hms_scan_display`

## Requirements
- R1: While reset is asserted, and at the first sample after it, the digit select and segment outputs are both 8'hFF, so all digits are dark.
- R2: After reset, exactly one digit-select bit is low. Slot k drives bit k low, so slot 0 gives 8'b11111110 and slot 7 gives 8'b01111111.
- R3: Each slot lasts exactly SLOT_CYCLES clocks. The slot then advances by one, and slot 7 wraps to slot 0. Slot 0 is the first slot shown after reset.
- R4: Slots map to the time input as follows: slot 0 shows time_bcd[3:0] (seconds units) and slot 1 shows [7:4] (seconds tens). Slot 3 shows [11:8] and slot 4 shows [15:12] (minutes). Slot 6 shows [19:16] and slot 7 shows [23:20] (hours). Slots 2 and 5 are separators.
- R5: Digit values use active-low segment codes: 0=C0, 1=F9, 2=A4, 3=B0, 4=99, 5=92, 6=82, 7=F8, 8=80, 9=90 (hex).
- R6: With blink_off low, a separator slot drives 8'hBF, which is a dash.
- R7: With blink_off high, a separator slot drives 8'hFF. Digit slots are not affected by blink_off.
- R8: A digit slot whose nibble is above 9 (A to F) drives 8'hFF, which is blank. It never shows a dash.
- R9: The digit select and the segment code come from the same clock edge. Both reflect the slot index and the inputs sampled at that edge. A time or blink change reaches the segments one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_bcd | input | 24 | Packed BCD time, hours tens in the top nibble and seconds units in the bottom nibble |
| blink_off | input | 1 | Blink phase; when high, the separators are blanked |
| dig_sel_n | output | 8 | Active-low one-hot digit enable |
| seg_n | output | 8 | Active-low segment pattern, bit 7 being the point |

## Verification
A slot advance can fall in the same cycle as a change of the time or of the blink phase. When that happens, the new slot must be drawn with the new input and must not carry the old slot's glyph. The bench runs with a four-cycle slot. In one sequence it toggles blink_off on every clock, and in another it rewrites every nibble of the time on every clock. As a result, input changes land on every slot boundary and on every position within a slot. Each registered output pair is compared against a slot index and a glyph that the bench derives from its own cycle count and from the inputs it drove just before that edge.

// File: rtl/hms_scan_pkg.sv
package hms_scan_pkg;
  localparam int NUM_SLOTS  = 8;
  localparam int NUM_DIGITS = 6;
  localparam int CODE_W     = 4;
  localparam int SEG_W      = 8;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);

  localparam logic [CODE_W-1:0] CODE_DASH  = 4'hA;
  localparam logic [CODE_W-1:0] CODE_BLANK = 4'hF;

  typedef enum logic {KIND_DIGIT, KIND_SEP} slot_kind_t;

  // every third slot, counted from 2, is a separator
  function automatic slot_kind_t kind_of(input logic [SLOT_W-1:0] s);
    return ((int'(s) % 3) == 2) ? KIND_SEP : KIND_DIGIT;
  endfunction

  // digit slots skip one separator per group of three
  function automatic logic [SLOT_W-1:0] nibble_of(input logic [SLOT_W-1:0] s);
    return SLOT_W'(int'(s) - int'(s) / 3);
  endfunction
endpackage

// File: rtl/hms_scan_timer.sv
module hms_scan_timer #(
  parameter int SLOT_CYCLES = 48000,
  parameter int NUM_SLOTS   = 8,
  parameter int SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam int DIV_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      slot_idx <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q    <= '0;
      slot_idx <= (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: a slot holds until its dwell count ends
  a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != DIV_LAST) |=> $stable(slot_idx));
  // R3: the last slot wraps to the first
  a_r3_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_LAST && slot_idx == SLOT_LAST) |=> (slot_idx == '0));
  // R3: other slots step by one
  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_LAST && slot_idx != SLOT_LAST) |=> (slot_idx == $past(slot_idx) + 1'b1));
endmodule

// File: rtl/hms_glyph_select.sv
module hms_glyph_select
  import hms_scan_pkg::*;
(
  input  logic [CODE_W*NUM_DIGITS-1:0] time_bcd,
  input  logic                         blink_off,
  input  logic [SLOT_W-1:0]            slot_idx,
  output logic [CODE_W-1:0]            code
);
  logic [CODE_W-1:0] nib [NUM_DIGITS];
  logic [SLOT_W-1:0] pos;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_nib
    assign nib[g] = time_bcd[g*CODE_W +: CODE_W];
  end

  assign pos = nibble_of(slot_idx);

  always_comb begin
    code = CODE_BLANK;
    if (kind_of(slot_idx) == KIND_SEP) begin
      code = blink_off ? CODE_BLANK : CODE_DASH;
    end else if (int'(pos) < NUM_DIGITS) begin
      code = (nib[pos] > 4'd9) ? CODE_BLANK : nib[pos];
    end
  end

  // R8: a digit slot never yields the dash code
  always_comb begin
    if (kind_of(slot_idx) == KIND_DIGIT)
      a_r8_no_dash_in_digit: assert (code != CODE_DASH);
  end
endmodule

// File: rtl/hms_seg_encoder.sv
module hms_seg_encoder
  import hms_scan_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [SEG_W-1:0]  seg_n
);
  always_comb begin
    unique case (code)
      4'h0:    seg_n = 8'hC0;
      4'h1:    seg_n = 8'hF9;
      4'h2:    seg_n = 8'hA4;
      4'h3:    seg_n = 8'hB0;
      4'h4:    seg_n = 8'h99;
      4'h5:    seg_n = 8'h92;
      4'h6:    seg_n = 8'h82;
      4'h7:    seg_n = 8'hF8;
      4'h8:    seg_n = 8'h80;
      4'h9:    seg_n = 8'h90;
      4'hA:    seg_n = 8'hBF;
      default: seg_n = 8'hFF;
    endcase
  end
endmodule

// File: rtl/hms_scan_display.sv
module hms_scan_display
  import hms_scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 48000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] time_bcd,
  input  logic        blink_off,
  output logic [7:0]  dig_sel_n,
  output logic [7:0]  seg_n
);
  logic [SLOT_W-1:0]    slot_idx;
  logic [CODE_W-1:0]    code;
  logic [SEG_W-1:0]     seg_next;
  logic [NUM_SLOTS-1:0] sel_next;
  logic                 live_q;

  hms_scan_timer #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_W     (SLOT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_idx(slot_idx)
  );

  hms_glyph_select u_glyph (
    .time_bcd (time_bcd),
    .blink_off(blink_off),
    .slot_idx (slot_idx),
    .code     (code)
  );

  hms_seg_encoder u_enc (
    .code (code),
    .seg_n(seg_next)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
    assign sel_next[g] = (slot_idx != SLOT_W'(g));
  end

  // select and segments leave through one register stage together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_sel_n <= '1;
      seg_n     <= '1;
      live_q    <= 1'b0;
    end else begin
      dig_sel_n <= sel_next;
      seg_n     <= seg_next;
      live_q    <= 1'b1;
    end
  end

  // R1: dark outputs right after reset
  a_r1_dark_after_reset: assert property (@(posedge clk)
    !rst_n |=> (dig_sel_n == 8'hFF && seg_n == 8'hFF));
  // R2: exactly one digit enabled once running
  a_r2_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ($countones(~dig_sel_n) == 1));
  // R6: dash in separator slots while blink phase was low
  a_r6_dash_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && (!dig_sel_n[2] || !dig_sel_n[5]) && !$past(blink_off)) |-> (seg_n == 8'hBF));
  // R7: separators dark while blink phase was high
  a_r7_dash_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && (!dig_sel_n[2] || !dig_sel_n[5]) && $past(blink_off)) |-> (seg_n == 8'hFF));
endmodule

// File: tb/sim_hms_scan_display.sv
module sim_hms_scan_display;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] t = '0;
  logic        blink = 1'b0;
  logic [7:0]  dig_sel_n, seg_n;

  typedef struct {
    logic [7:0] dig;
    logic [7:0] seg;
    string      dtag;
    string      stag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          failures = 0;
  int          n = 0;
  int          prev_slot = 0;
  logic [23:0] prev_t = '0;
  bit          done = 0;

  always #2 clk = ~clk;

  hms_scan_display #(.SLOT_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .time_bcd(t), .blink_off(blink),
    .dig_sel_n(dig_sel_n), .seg_n(seg_n)
  );

  function automatic logic [7:0] glyph(input logic [3:0] v);
    case (v)
      4'd0: return 8'hC0; 4'd1: return 8'hF9; 4'd2: return 8'hA4;
      4'd3: return 8'hB0; 4'd4: return 8'h99; 4'd5: return 8'h92;
      4'd6: return 8'h82; 4'd7: return 8'hF8; 4'd8: return 8'h80;
      4'd9: return 8'h90; default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // driver: expected result of the next edge from inputs now applied
  task automatic push_exp();
    exp_t e;
    int slot = ((n - 1) / S) % 8;
    int nib_i;
    logic [3:0] v;
    e.dig  = ~(8'b1 << slot);
    e.dtag = (n > 1 && slot != prev_slot) ? "R3" : "R2";
    if (slot == 2 || slot == 5) begin
      e.seg  = blink ? 8'hFF : 8'hBF;
      e.stag = blink ? "R7" : "R6";
    end else begin
      case (slot)
        0: nib_i = 0; 1: nib_i = 1; 3: nib_i = 2;
        4: nib_i = 3; 6: nib_i = 4; default: nib_i = 5;
      endcase
      v = t[nib_i*4 +: 4];
      e.seg = glyph(v);
      if (v > 4'd9)      e.stag = "R8";
      else if (t != prev_t) e.stag = "R9";
      else               e.stag = "R4,R5";
    end
    prev_slot = slot;
    prev_t    = t;
    q.push_back(e);
  endtask

  // monitor: compare the edge just passed with the queued expectation
  task automatic pop_check();
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.dtag, "dig_sel_n", dig_sel_n, e.dig);
      check(e.stag, "seg_n", seg_n, e.seg);
    end
  endtask

  task automatic step(input logic [23:0] tv, input logic bv);
    @(negedge clk);
    pop_check();
    t = tv;
    blink = bv;
    n++;
    push_exp();
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1", "dig_sel_n in reset", dig_sel_n, 8'hFF);
      check("R1", "seg_n in reset", seg_n, 8'hFF);
    end
    // release reset; first edge after it shows slot 0
    @(negedge clk);
    rst_n = 1'b1;
    t = 24'h235959;
    prev_t = t;
    blink = 1'b0;
    n = 1;
    push_exp();
    for (int i = 0; i < 64; i++) step(24'h235959, 1'b0);
    for (int i = 0; i < 32; i++) step(24'h235959, 1'b1);
    for (int i = 0; i < 64; i++) step(24'h012345, i[0]);
    for (int i = 0; i < 32; i++) step(24'hFAB9C0, 1'b0);
    for (int i = 0; i < 64; i++) step({6{4'(i % 10)}}, i[3]);
    @(negedge clk);
    pop_check();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule